// File: doc/BRIEF.md
# Configurable 3x3 Neighbourhood Window Processor

The block takes a raster image one pixel at a time and keeps the two previous image rows in internal line delays, so each pixel enters only once. From these delays and a small shift window it builds a 3x3 neighbourhood. Nine processing elements work on that neighbourhood in parallel. Each element combines its pixel with a stored weight, either by multiplying or by adding. A reduction stage then folds the nine values into one result by summing, by taking the maximum or by taking the minimum.

This framework covers six operators: convolution, absolute convolution, multiplicative maximum and minimum, and additive maximum and minimum. Each template position carries a used flag. A position with the flag cleared takes no part in the reduction. The block has two window modes. In overlapping mode every full window yields a result. In tiled mode the window steps by three in both directions.

Operation, mode, image width, weights and flags are captured when a frame starts and are held for the whole frame. Arithmetic is word-parallel two's complement.

Top module: `win3x3_proc`

## Requirements
- R1: After reset `res_valid` is low, and pixels that arrive before the first `frame_start` pulse produce no result.
- R2: `cfg_op`, `cfg_tile`, `cfg_width`, `cfg_wgt` and `cfg_used` are sampled only in a cycle with `frame_start` high. Changing them during the frame has no effect on that frame's results.
- R3: In overlapping mode (`cfg_tile`=0) there is one result for every window whose top-left pixel (r0,c0) satisfies r0 ≤ H-3 and c0 ≤ W-3. Results come in raster order, which gives (W-2)·(H-2) results per frame. The pixel that completes a window is sampled on a rising edge, and its result is valid in the cycle after the next rising edge.
- R4: In tiled mode (`cfg_tile`=1) only windows with r0 and c0 both multiples of 3 produce a result, which gives floor(W/3)·floor(H/3) results. Two results are never in adjacent cycles.
- R5: Convolution (`cfg_op`=0) outputs the sum over used positions of pixel·w. Position p=3·r+c uses bits [8p+7:8p] of `cfg_wgt`, where r=0 is the oldest row and c=0 is the leftmost column. For multiply operations, w is the low 6 bits of that field as two's complement. Pixels are 8-bit unsigned.
- R6: Absolute convolution (`cfg_op`=1) outputs the magnitude of the convolution result, which is never negative.
- R7: Multiplicative maximum (`cfg_op`=2) and multiplicative minimum (`cfg_op`=3) output the largest or smallest pixel·w over the used positions.
- R8: Additive maximum (`cfg_op`=4) and additive minimum (`cfg_op`=5) output the largest or smallest pixel+w over the used positions. Here w is the full 8-bit field as two's complement.
- R9: A position whose `cfg_used` bit p is 0 does not affect the result. A window with every position unused outputs the reduction's identity value:
  - 0 for sum and absolute sum;
  - -262144 for maximum;
  - 262143 for minimum.
- R10: `res_data` is 19-bit two's complement. Op codes 6 and 7 behave as convolution.
- R11: Idle cycles with `pix_valid` low between pixels do not change any result value or the result count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Starts a frame and captures the configuration |
| cfg_width | input | 7 | Image width in pixels (3 to 64) |
| cfg_op | input | 3 | Operator select |
| cfg_tile | input | 1 | 1 selects tiled window steps |
| cfg_wgt | input | 72 | Nine 8-bit weight fields |
| cfg_used | input | 9 | Per-position used flags |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | 8 | Unsigned pixel |
| res_valid | output | 1 | Result present this cycle |
| res_data | output | 19 | Signed result |

## Verification
Each operator is run over three images:
- a smooth pseudo-random image, where a wrong window position or weight order gives wrong sums;
- a 0/255 checkerboard, where the sign of products, the magnitude stage and the extreme weights -32, 31, -128 and 127 are exercised;
- a ramp, where a row or column swap changes the result.

Templates with a cleared centre, a sparse pattern and no used position at all separate correct bypass from identity seeding. A weight field with high bits set shows that multiply weights use only six bits. Frames with idle gaps and two widths, in both window modes, check the result count and order. A mid-frame change to the configuration inputs shows that settings are held.

// File: rtl/win_pkg.sv
package win_pkg;
    localparam int WIN  = 3;
    localparam int TAPS = WIN * WIN;

    typedef enum logic [2:0] {
        OP_CONV  = 3'd0,
        OP_ACONV = 3'd1,
        OP_MMAX  = 3'd2,
        OP_MMIN  = 3'd3,
        OP_AMAX  = 3'd4,
        OP_AMIN  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        RED_SUM = 2'd0,
        RED_MAX = 2'd1,
        RED_MIN = 2'd2
    } red_e;
endpackage

// File: rtl/win_linebuf.sv
module win_linebuf #(
    parameter int PIX_W = 8,
    parameter int MAX_W = 64,
    localparam int CB = $clog2(MAX_W)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [CB-1:0]    col,
    input  logic [PIX_W-1:0] din,
    output logic [PIX_W-1:0] row1,
    output logic [PIX_W-1:0] row2
);
    logic [PIX_W-1:0] mem1 [MAX_W];
    logic [PIX_W-1:0] mem2 [MAX_W];

    // one write per pixel: the current row moves into the first delay, and
    // the first delay's entry moves into the second
    always_ff @(posedge clk) begin
        if (we) begin
            mem1[col] <= din;
            mem2[col] <= mem1[col];
        end
    end

    assign row1 = mem1[col];
    assign row2 = mem2[col];
endmodule

// File: rtl/win_pe.sv
module win_pe #(
    parameter int PIX_W = 8,
    parameter int WGT_W = 8,
    parameter int MUL_W = 6,
    parameter int VAL_W = 19
) (
    input  logic [PIX_W-1:0]        pix,
    input  logic [WGT_W-1:0]        wgt,
    input  logic                    use_mul,
    output logic signed [VAL_W-1:0] val
);
    logic signed [PIX_W:0]     px;
    logic signed [MUL_W-1:0]   wm;
    logic signed [WGT_W-1:0]   wa;
    logic signed [VAL_W-1:0]   prod;
    logic signed [VAL_W-1:0]   addv;

    assign px   = {1'b0, pix};
    assign wm   = wgt[MUL_W-1:0];
    assign wa   = wgt;
    assign prod = VAL_W'(px) * VAL_W'(wm);
    assign addv = VAL_W'(px) + VAL_W'(wa);
    assign val  = use_mul ? prod : addv;
endmodule

// File: rtl/win_reduce.sv
module win_reduce
    import win_pkg::*;
#(
    parameter int N     = 9,
    parameter int VAL_W = 19
) (
    input  logic signed [VAL_W-1:0] vals [N],
    input  logic [N-1:0]            used,
    input  red_e                    red,
    input  logic                    abs_en,
    output logic signed [VAL_W-1:0] res
);
    localparam logic signed [VAL_W-1:0] MOST_NEG = {1'b1, {(VAL_W-1){1'b0}}};
    localparam logic signed [VAL_W-1:0] MOST_POS = {1'b0, {(VAL_W-1){1'b1}}};

    logic signed [VAL_W-1:0] acc;

    always_comb begin
        case (red)
            RED_MAX: acc = MOST_NEG;
            RED_MIN: acc = MOST_POS;
            default: acc = '0;
        endcase
        for (int i = 0; i < N; i++) begin
            if (used[i]) begin
                case (red)
                    RED_MAX: if (vals[i] > acc) acc = vals[i];
                    RED_MIN: if (vals[i] < acc) acc = vals[i];
                    default: acc = acc + vals[i];
                endcase
            end
        end
        if (abs_en && acc < 0) acc = -acc;
        res = acc;
    end
endmodule

// File: rtl/win3x3_proc.sv
module win3x3_proc
    import win_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int WGT_W    = 8,
    parameter int MUL_W    = 6,
    parameter int MAX_W    = 64,
    parameter int ROW_BITS = 12,
    localparam int CB     = $clog2(MAX_W),
    localparam int WB     = $clog2(MAX_W + 1),
    localparam int PROD_W = PIX_W + 1 + MUL_W,
    localparam int ADD_W  = ((PIX_W + 1 > WGT_W) ? PIX_W + 1 : WGT_W) + 1,
    localparam int LOC_W  = (PROD_W > ADD_W) ? PROD_W : ADD_W,
    localparam int RES_W  = LOC_W + $clog2(TAPS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_start,
    input  logic [WB-1:0]          cfg_width,
    input  logic [2:0]             cfg_op,
    input  logic                   cfg_tile,
    input  logic [TAPS*WGT_W-1:0]  cfg_wgt,
    input  logic [TAPS-1:0]        cfg_used,
    input  logic                   pix_valid,
    input  logic [PIX_W-1:0]       pix_data,
    output logic                   res_valid,
    output logic [RES_W-1:0]       res_data
);
    typedef struct packed {
        logic                  active;
        logic [WB-1:0]         width;
        logic [2:0]            op;
        logic                  tile;
        logic [TAPS*WGT_W-1:0] wgt;
        logic [TAPS-1:0]       used;
        logic [CB-1:0]         col;
        logic [ROW_BITS-1:0]   row;
        logic [1:0]            cmod;
        logic [1:0]            rmod;
        logic [TAPS*PIX_W-1:0] win;
        logic                  win_v;
        logic [RES_W-1:0]      res;
        logic                  res_v;
    } st_t;

    st_t q, d;

    logic                    take_pix;
    logic [PIX_W-1:0]        lb_row1, lb_row2;
    logic [PIX_W-1:0]        new_col [WIN];
    logic                    use_mul, abs_en;
    red_e                    red;
    logic signed [RES_W-1:0] pe_val [TAPS];
    logic signed [RES_W-1:0] red_out;

    assign take_pix = pix_valid && q.active && !frame_start;

    win_linebuf #(.PIX_W(PIX_W), .MAX_W(MAX_W)) u_lb (
        .clk  (clk),
        .we   (take_pix),
        .col  (q.col),
        .din  (pix_data),
        .row1 (lb_row1),
        .row2 (lb_row2)
    );

    assign new_col[0] = lb_row2;
    assign new_col[1] = lb_row1;
    assign new_col[2] = pix_data;

    // operator decode from the frame's held selection
    always_comb begin
        use_mul = 1'b1;
        abs_en  = 1'b0;
        red     = RED_SUM;
        case (op_e'(q.op))
            OP_ACONV: abs_en = 1'b1;
            OP_MMAX:  red = RED_MAX;
            OP_MMIN:  red = RED_MIN;
            OP_AMAX:  begin use_mul = 1'b0; red = RED_MAX; end
            OP_AMIN:  begin use_mul = 1'b0; red = RED_MIN; end
            default:  ;
        endcase
    end

    for (genvar p = 0; p < TAPS; p++) begin : g_pe
        win_pe #(
            .PIX_W(PIX_W), .WGT_W(WGT_W), .MUL_W(MUL_W), .VAL_W(RES_W)
        ) u_pe (
            .pix     (q.win[p*PIX_W +: PIX_W]),
            .wgt     (q.wgt[p*WGT_W +: WGT_W]),
            .use_mul (use_mul),
            .val     (pe_val[p])
        );
    end

    win_reduce #(.N(TAPS), .VAL_W(RES_W)) u_red (
        .vals   (pe_val),
        .used   (q.used),
        .red    (red),
        .abs_en (abs_en),
        .res    (red_out)
    );

    always_comb begin
        d       = q;
        d.win_v = 1'b0;
        d.res_v = q.win_v;
        d.res   = red_out;
        if (frame_start) begin
            d.active = 1'b1;
            d.width  = cfg_width;
            d.op     = cfg_op;
            d.tile   = cfg_tile;
            d.wgt    = cfg_wgt;
            d.used   = cfg_used;
            d.col    = '0;
            d.row    = '0;
            d.cmod   = '0;
            d.rmod   = '0;
        end else if (take_pix) begin
            for (int r = 0; r < WIN; r++) begin
                d.win[(WIN*r)*PIX_W +: PIX_W]     = q.win[(WIN*r+1)*PIX_W +: PIX_W];
                d.win[(WIN*r+1)*PIX_W +: PIX_W]   = q.win[(WIN*r+2)*PIX_W +: PIX_W];
                d.win[(WIN*r+2)*PIX_W +: PIX_W]   = new_col[r];
            end
            d.win_v = (q.row >= ROW_BITS'(WIN-1)) && (q.col >= CB'(WIN-1)) &&
                      (!q.tile || (q.rmod == 2'(WIN-1) && q.cmod == 2'(WIN-1)));
            if (WB'(q.col) == q.width - WB'(1)) begin
                d.col  = '0;
                d.cmod = '0;
                if (q.row != '1) d.row = q.row + ROW_BITS'(1);
                d.rmod = (q.rmod == 2'(WIN-1)) ? 2'd0 : q.rmod + 2'd1;
            end else begin
                d.col  = q.col + CB'(1);
                d.cmod = (q.cmod == 2'(WIN-1)) ? 2'd0 : q.cmod + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res_valid = q.res_v;
    assign res_data  = q.res;
endmodule

// File: rtl/win3x3_chk.sv
module win3x3_chk #(
    parameter int PIX_W = 8,
    parameter int MUL_W = 6,
    parameter int RES_W = 19,
    parameter int TAPS  = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic [2:0]       cfg_op,
    input logic             cfg_tile,
    input logic             pix_valid,
    input logic             res_valid,
    input logic [RES_W-1:0] res_data
);
    localparam int BOUND = TAPS * ((2 ** PIX_W) - 1) * (2 ** (MUL_W - 1));

    logic [2:0] op_q;
    logic       tile_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            tile_q <= 1'b0;
        end else if (frame_start) begin
            op_q   <= cfg_op;
            tile_q <= cfg_tile;
        end
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) !rst_n |=> !res_valid); // R1

    AST_RESULT_FROM_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(pix_valid, 2) && !$past(frame_start, 2))); // R3

    AST_TILE_NOT_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && tile_q && !$past(frame_start)) |=> !res_valid); // R4

    AST_ABS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && op_q == 3'd1 && !$past(frame_start)) |-> !res_data[RES_W-1]); // R6

    AST_CONV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (op_q == 3'd0 || op_q >= 3'd6) && !$past(frame_start)) |->
        ($signed(res_data) <= BOUND && $signed(res_data) >= -BOUND)); // R10
endmodule

bind win3x3_proc win3x3_chk #(
    .PIX_W(PIX_W), .MUL_W(MUL_W), .RES_W(RES_W), .TAPS(win_pkg::TAPS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_op(cfg_op),
    .cfg_tile(cfg_tile), .pix_valid(pix_valid), .res_valid(res_valid),
    .res_data(res_data)
);

// File: tb/sim_win3x3_proc.sv
module sim_win3x3_proc;
    localparam int RW = 19;
    localparam int IH = 6;
    localparam int NV = 12;
    localparam logic [71:0] WA = 72'h1F_20_C5_3F_04_3F_02_11_07;
    localparam logic [71:0] WB = 72'h80_7F_10_F0_00_05_FB_20_01;
    localparam logic [71:0] W1 = {9{8'h01}};
    localparam logic [71:0] W2 = {9{8'h02}};

    typedef struct packed {
        logic [2:0]  op;
        logic        tile;
        logic [1:0]  pat;
        logic        gap;
        logic [4:0]  width;
        logic [8:0]  used;
        logic [71:0] wgt;
        logic [7:0]  cnt;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 2'd0, 1'b0, 5'd7, 9'h1FF, WA, 8'd20},
        '{3'd1, 1'b0, 2'd1, 1'b0, 5'd7, 9'h1FF, WA, 8'd20},
        '{3'd2, 1'b0, 2'd0, 1'b1, 5'd9, 9'h1EF, WA, 8'd28},
        '{3'd3, 1'b0, 2'd2, 1'b0, 5'd7, 9'h155, WA, 8'd20},
        '{3'd4, 1'b0, 2'd0, 1'b0, 5'd7, 9'h1FF, WB, 8'd20},
        '{3'd5, 1'b1, 2'd1, 1'b0, 5'd9, 9'h0FE, WB, 8'd6},
        '{3'd0, 1'b1, 2'd2, 1'b1, 5'd7, 9'h1FF, WA, 8'd4},
        '{3'd2, 1'b0, 2'd0, 1'b0, 5'd7, 9'h000, WA, 8'd20},
        '{3'd5, 1'b0, 2'd0, 1'b0, 5'd7, 9'h000, WB, 8'd20},
        '{3'd0, 1'b0, 2'd1, 1'b0, 5'd7, 9'h000, WA, 8'd20},
        '{3'd6, 1'b0, 2'd0, 1'b0, 5'd7, 9'h1FF, WA, 8'd20},
        '{3'd1, 1'b1, 2'd0, 1'b0, 5'd9, 9'h1FF, WA, 8'd6}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic [6:0]    cfg_width = '0;
    logic [2:0]    cfg_op = '0;
    logic          cfg_tile = 1'b0;
    logic [71:0]   cfg_wgt = '0;
    logic [8:0]    cfg_used = '0;
    logic          pix_valid = 1'b0;
    logic [7:0]    pix_data = '0;
    logic          res_valid;
    logic [RW-1:0] res_data;

    int n_cmp = 0;
    int n_bad = 0;
    int n_got = 0;
    logic [RW-1:0] got [512];

    always #5 clk = ~clk;

    win3x3_proc u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_width(cfg_width),
        .cfg_op(cfg_op), .cfg_tile(cfg_tile), .cfg_wgt(cfg_wgt), .cfg_used(cfg_used),
        .pix_valid(pix_valid), .pix_data(pix_data), .res_valid(res_valid),
        .res_data(res_data)
    );

    always @(negedge clk) begin
        if (res_valid && n_got < 512) begin
            got[n_got] = res_data;
            n_got++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pix_at(input int pat, input int r, input int c);
        case (pat)
            1:       return ((r + c) & 1) ? 255 : 0;
            2:       return (r * 16 + c * 9) & 255;
            default: return (r * 53 + c * 29 + r * c * 7 + 11) & 255;
        endcase
    endfunction

    function automatic string op_tag(input int op);
        case (op)
            1:       return "R6";
            2, 3:    return "R7";
            4, 5:    return "R8";
            6, 7:    return "R10";
            default: return "R5";
        endcase
    endfunction

    function automatic int model(input int pat, input int op, input logic [8:0] used,
                                 input logic [71:0] wg, input int r0, input int c0);
        int acc, red, px, wv, v;
        bit mul;
        mul = !(op == 4 || op == 5);
        red = (op == 2 || op == 4) ? 1 : (op == 3 || op == 5) ? 2 : 0;
        acc = (red == 1) ? -(1 << 18) : (red == 2) ? (1 << 18) - 1 : 0;
        for (int p = 0; p < 9; p++) begin
            if (used[p]) begin
                px = pix_at(pat, r0 + p / 3, c0 + p % 3);
                if (mul) begin
                    wv = int'(wg[p*8 +: 8]) & 63;
                    if (wv >= 32) wv -= 64;
                    v = px * wv;
                end else begin
                    wv = int'(wg[p*8 +: 8]);
                    if (wv >= 128) wv -= 256;
                    v = px + wv;
                end
                if (red == 1) begin if (v > acc) acc = v; end
                else if (red == 2) begin if (v < acc) acc = v; end
                else acc += v;
            end
        end
        if (op == 1 && acc < 0) acc = -acc;
        return acc;
    endfunction

    function automatic int sval(input logic [RW-1:0] x);
        return int'($signed(x));
    endfunction

    task automatic start_frame(input int w, input int op, input bit tile,
                               input logic [8:0] used, input logic [71:0] wg);
        @(negedge clk);
        frame_start = 1'b1;
        cfg_width   = 7'(w);
        cfg_op      = 3'(op);
        cfg_tile    = tile;
        cfg_used    = used;
        cfg_wgt     = wg;
        pix_valid   = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic send_pix(input int v);
        pix_valid = 1'b1;
        pix_data  = 8'(v);
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int base, k, exp, step;
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1 res_valid during reset", int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_valid == 1'b0, "R1 res_valid after reset", int'(res_valid), 0);

        // R1: pixels before any frame start give nothing
        cfg_width = 7'd3;
        base = n_got;
        for (int i = 0; i < 30; i++) send_pix(i * 7);
        repeat (4) @(negedge clk);
        check(n_got == base, "R1 no output before frame start", n_got - base, 0);

        // table walk: R3 R4 R5 R6 R7 R8 R9 R10 R11
        for (int v = 0; v < NV; v++) begin
            start_frame(int'(VECS[v].width), int'(VECS[v].op), VECS[v].tile,
                        VECS[v].used, VECS[v].wgt);
            base = n_got;
            for (int r = 0; r < IH; r++) begin
                for (int c = 0; c < int'(VECS[v].width); c++) begin
                    send_pix(pix_at(int'(VECS[v].pat), r, c));
                    if (VECS[v].gap && (c % 2 == 1)) @(negedge clk);
                end
            end
            repeat (4) @(negedge clk);
            check(n_got - base == int'(VECS[v].cnt),
                  VECS[v].tile ? "R4 tiled result count" :
                  (VECS[v].gap ? "R11 result count with gaps" : "R3 overlap result count"),
                  n_got - base, int'(VECS[v].cnt));
            step = VECS[v].tile ? 3 : 1;
            k = 0;
            for (int r0 = 0; r0 + 2 < IH; r0 += step) begin
                for (int c0 = 0; c0 + 2 < int'(VECS[v].width); c0 += step) begin
                    exp = model(int'(VECS[v].pat), int'(VECS[v].op), VECS[v].used,
                                VECS[v].wgt, r0, c0);
                    if (base + k < n_got)
                        check(sval(got[base + k]) == exp,
                              (VECS[v].used == 9'h000) ? "R9 identity value" : op_tag(int'(VECS[v].op)),
                              sval(got[base + k]), exp);
                    k++;
                end
            end
        end

        // R3: latency of the first window of a 3x3 frame
        start_frame(3, 0, 1'b0, 9'h1FF, W1);
        base = n_got;
        for (int i = 1; i <= 8; i++) send_pix(i);
        pix_valid = 1'b1;
        pix_data  = 8'd9;
        @(negedge clk);
        pix_valid = 1'b0;
        check(res_valid == 1'b0, "R3 latency: not yet valid", int'(res_valid), 0);
        @(negedge clk);
        check(res_valid == 1'b1, "R3 latency: valid", int'(res_valid), 1);
        check(sval(res_data) == 45, "R3 latency: value", sval(res_data), 45);
        @(negedge clk);
        check(res_valid == 1'b0, "R3 latency: single pulse", int'(res_valid), 0);

        // R2: configuration changed mid-frame is ignored
        start_frame(3, 0, 1'b0, 9'h1FF, W1);
        base = n_got;
        for (int i = 1; i <= 4; i++) send_pix(i);
        cfg_wgt   = W2;
        cfg_op    = 3'd2;
        cfg_used  = 9'h000;
        cfg_tile  = 1'b1;
        cfg_width = 7'd5;
        for (int i = 5; i <= 9; i++) send_pix(i);
        repeat (4) @(negedge clk);
        check(n_got - base == 1, "R2 held config count", n_got - base, 1);
        if (n_got > base)
            check(sval(got[base]) == 45, "R2 held config value", sval(got[base]), 45);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule